// File: doc/BRIEF.md
# Voice PCM Frame Serial Port

This block is the digital serial port of a narrow-band voice codec. A host-side clock (the design clock, taken as the inverted master bit clock) drives every transfer, and an external frame sync pulse marks the start of each frame. On every frame the port moves one transmit word out of a serial data pin and one receive word in from a serial data pin, most significant bit first. A mode input picks between an 8-bit companded code and a 16-bit linear slot. The linear slot carries a 13-bit two's-complement sample followed by a 3-bit receive volume code.

The parallel side takes a transmit sample with a valid strobe and keeps it until it is replaced. It returns each received sample together with its volume code, marked by a one-cycle valid strobe. The port also measures the spacing between successive sync pulses against the expected frame length. It flags any frame that is too short or too long and realigns to the newest sync. Companding arithmetic, filtering and conversion are handled elsewhere.

Top module: `pcm_voice_port`

## Requirements
- R1: After synchronous reset, tx_oe_o, rx_valid_o and frame_err_o are 0 and rx_sample_o and rx_vol_o are 0.
- R2: A slot starts on the clock edge that first samples sync_i high after a low (the sync edge). Bit 0 of the slot appears on tx_bit_o right after that edge, and rx_bit_i is sampled for bit 0 on the next edge.
- R3: Both directions shift most significant bit first.
- R4: comp_sel_i is sampled on the sync edge. Low (0) selects a 16-bit linear slot and high (1) selects an 8-bit companded slot. Changes during the slot have no effect.
- R5: In a linear slot, the first 13 received bits form rx_sample_o (two's complement, sign bit first) and the last 3 form rx_vol_o.
- R6: In a linear slot, the transmitted bits are tx_data_i[12:0] followed by three 0 bits. In a companded slot they are tx_data_i[7:0].
- R7: tx_oe_o is 1 exactly while slot bits are driven: from the sync edge until the edge that samples the last bit. It is 0 otherwise.
- R8: rx_valid_o pulses for one cycle on the edge that samples the last bit, with rx_sample_o and rx_vol_o updated together. In companded mode, rx_sample_o holds the code in bits [7:0] with upper bits 0, and rx_vol_o is 3'b001 (unity gain).
- R9: frame_err_o pulses for one cycle on a sync edge whose distance from the previous sync edge is not FRAME_LEN clocks. The first sync edge after reset never flags.
- R10: A sync edge during an active slot abandons that slot without a valid strobe and starts a new slot. Frame length is measured from the new sync edge onward.
- R11: tx_valid_i captures tx_data_i into a holding register. The held word is loaded at each sync edge and reused in later frames until it is replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; rising edge is the sampling edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync pulse |
| comp_sel_i | input | 1 | Slot mode: 0 linear, 1 companded |
| rx_bit_i | input | 1 | Serial receive data |
| tx_data_i | input | 13 | Parallel transmit sample |
| tx_valid_i | input | 1 | Capture strobe for tx_data_i |
| tx_bit_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit drive enable; 0 means high impedance |
| rx_sample_o | output | 13 | Received sample or companded code |
| rx_vol_o | output | 3 | Received volume code |
| rx_valid_o | output | 1 | One-cycle strobe for a completed receive word |
| frame_err_o | output | 1 | One-cycle frame-length error pulse |

## Verification
The bench overrides FRAME_LEN to 32 instead of 256. This keeps a full frame short enough that many frames fit in one run while leaving room for a 16-bit slot plus idle gap. With that value, the run reaches short frames (29), long frames (40), an aborted slot and recovery, along with mode changes from one frame to the next. A sync edge landing mid-slot and held transmit words spanning several frames are also within reach cheaply.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int SAMPLE_W = 13;
    localparam int VOL_W    = 3;
    localparam int CODE_W   = 8;
    localparam int SLOT_W   = SAMPLE_W + VOL_W;
    localparam int BITCNT_W = $clog2(SLOT_W + 1);

    localparam logic [VOL_W-1:0] VOL_UNITY = 3'b001;

    typedef enum logic {
        MODE_LINEAR  = 1'b0,
        MODE_COMPAND = 1'b1
    } slot_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        logic [VOL_W-1:0]    vol;
    } rx_word_t;

    function automatic logic [BITCNT_W-1:0] slot_bits(slot_mode_e m);
        return (m == MODE_COMPAND) ? BITCNT_W'(CODE_W) : BITCNT_W'(SLOT_W);
    endfunction

    function automatic logic [SLOT_W-1:0] pack_tx(slot_mode_e m, logic [SAMPLE_W-1:0] s);
        if (m == MODE_COMPAND)
            return {s[CODE_W-1:0], {(SLOT_W-CODE_W){1'b0}}};
        return {s, {VOL_W{1'b0}}};
    endfunction

    function automatic rx_word_t unpack_rx(slot_mode_e m, logic [SLOT_W-1:0] w);
        rx_word_t r;
        if (m == MODE_COMPAND) begin
            r.sample = {{(SAMPLE_W-CODE_W){1'b0}}, w[CODE_W-1:0]};
            r.vol    = VOL_UNITY;
        end else begin
            r.sample = w[SLOT_W-1:VOL_W];
            r.vol    = w[VOL_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
    parameter int FRAME_LEN = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic start_o,
    output logic frame_err_o
);
    localparam int FCNT_W = $clog2(FRAME_LEN + 2);
    localparam logic [FCNT_W-1:0] CNT_SAT  = FCNT_W'(FRAME_LEN + 1);
    localparam logic [FCNT_W-1:0] CNT_GOOD = FCNT_W'(FRAME_LEN);

    logic              sync_q;
    logic              locked_q;
    logic [FCNT_W-1:0] dist_q;

    assign start_o = sync_i && !sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q      <= 1'b0;
            locked_q    <= 1'b0;
            dist_q      <= '0;
            frame_err_o <= 1'b0;
        end else begin
            sync_q      <= sync_i;
            frame_err_o <= 1'b0;
            if (start_o) begin
                frame_err_o <= locked_q && (dist_q != CNT_GOOD);
                locked_q    <= 1'b1;
                dist_q      <= FCNT_W'(1);
            end else if (dist_q != CNT_SAT) begin
                dist_q <= dist_q + 1'b1;
            end
        end
    end

    // R9
    err_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> $past(start_o));

    // R9
    good_len_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (start_o && locked_q && dist_q == CNT_GOOD) |=> !frame_err_o);

endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       comp_sel_i,
    output logic       active_o,
    output logic       last_o,
    output slot_mode_e mode_o
);
    logic [BITCNT_W-1:0] idx_q;
    logic [BITCNT_W-1:0] len_q;

    assign last_o = active_o && (idx_q == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            idx_q    <= '0;
            len_q    <= BITCNT_W'(SLOT_W);
            mode_o   <= MODE_LINEAR;
        end else if (start_i) begin
            active_o <= 1'b1;
            idx_q    <= '0;
            mode_o   <= slot_mode_e'(comp_sel_i);
            len_q    <= slot_bits(slot_mode_e'(comp_sel_i));
        end else if (active_o) begin
            idx_q <= idx_q + 1'b1;
            if (last_o)
                active_o <= 1'b0;
        end
    end

    // R2
    slot_opens_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active_o) |-> $past(start_i));

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                comp_sel_i,
    input  logic                active_i,
    input  logic [SAMPLE_W-1:0] data_i,
    input  logic                valid_i,
    output logic                bit_o
);
    logic [SAMPLE_W-1:0] hold_q;
    logic [SLOT_W-1:0]   sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            sh_q   <= '0;
        end else begin
            if (valid_i)
                hold_q <= data_i;
            if (start_i)
                sh_q <= pack_tx(slot_mode_e'(comp_sel_i), hold_q);
            else if (active_i)
                sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
        end
    end

    assign bit_o = sh_q[SLOT_W-1];

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       active_i,
    input  logic       last_i,
    input  slot_mode_e mode_i,
    input  logic       bit_i,
    output rx_word_t   word_o,
    output logic       valid_o
);
    logic [SLOT_W-1:0] sh_q;
    logic [SLOT_W-1:0] full_w;

    assign full_w = {sh_q[SLOT_W-2:0], bit_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= last_i && !start_i;
            if (start_i)
                sh_q <= '0;
            else if (active_i)
                sh_q <= full_w;
            if (last_i && !start_i)
                word_o <= unpack_rx(mode_i, full_w);
        end
    end

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R8
    compand_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && mode_i == MODE_COMPAND)
            |-> (word_o.sample[SAMPLE_W-1:CODE_W] == '0 && word_o.vol == VOL_UNITY));

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int FRAME_LEN = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_i,
    input  logic                comp_sel_i,
    input  logic                rx_bit_i,
    input  logic [SAMPLE_W-1:0] tx_data_i,
    input  logic                tx_valid_i,
    output logic                tx_bit_o,
    output logic                tx_oe_o,
    output logic [SAMPLE_W-1:0] rx_sample_o,
    output logic [VOL_W-1:0]    rx_vol_o,
    output logic                rx_valid_o,
    output logic                frame_err_o
);
    logic       start_w;
    logic       active_w;
    logic       last_w;
    slot_mode_e mode_w;
    rx_word_t   rx_word_w;

    pcm_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .sync_i     (sync_i),
        .start_o    (start_w),
        .frame_err_o(frame_err_o)
    );

    pcm_slot_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_w),
        .comp_sel_i(comp_sel_i),
        .active_o  (active_w),
        .last_o    (last_w),
        .mode_o    (mode_w)
    );

    pcm_tx_shifter u_tx (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_w),
        .comp_sel_i(comp_sel_i),
        .active_i  (active_w),
        .data_i    (tx_data_i),
        .valid_i   (tx_valid_i),
        .bit_o     (tx_bit_o)
    );

    pcm_rx_shifter u_rx (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_w),
        .active_i(active_w),
        .last_i  (last_w),
        .mode_i  (mode_w),
        .bit_i   (rx_bit_i),
        .word_o  (rx_word_w),
        .valid_o (rx_valid_o)
    );

    assign tx_oe_o     = active_w;
    assign rx_sample_o = rx_word_w.sample;
    assign rx_vol_o    = rx_word_w.vol;

    // R7
    drive_off_at_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |-> !tx_oe_o);

endmodule

// File: tb/pcm_voice_port_test.sv
module pcm_voice_port_test;
    localparam int FL = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_i = 1'b0;
    logic        comp_sel_i = 1'b0;
    logic        rx_bit_i = 1'b0;
    logic [12:0] tx_data_i = '0;
    logic        tx_valid_i = 1'b0;
    logic        tx_bit_o, tx_oe_o, rx_valid_o, frame_err_o;
    logic [12:0] rx_sample_o;
    logic [2:0]  rx_vol_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pcm_voice_port #(.FRAME_LEN(FL)) uut (
        .clk(clk), .rst(rst), .sync_i(sync_i), .comp_sel_i(comp_sel_i),
        .rx_bit_i(rx_bit_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
        .tx_bit_o(tx_bit_o), .tx_oe_o(tx_oe_o), .rx_sample_o(rx_sample_o),
        .rx_vol_o(rx_vol_o), .rx_valid_o(rx_valid_o), .frame_err_o(frame_err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 oe", 32'(tx_oe_o), 0);
        check("R1 valid", 32'(rx_valid_o), 0);
        check("R1 err", 32'(frame_err_o), 0);
        check("R1 sample", 32'(rx_sample_o), 0);
        check("R1 vol", 32'(rx_vol_o), 0);
    endtask

    task automatic load_tx(input logic [12:0] w);
        @(negedge clk);
        tx_data_i  = w;
        tx_valid_i = 1'b1;
        @(negedge clk);
        tx_valid_i = 1'b0;
    endtask

    // Entered at a negedge with sync_i already driven high.
    task automatic run_frame(input bit mode, input logic [15:0] rx_slot,
                             input logic [15:0] exp_tx, input logic [12:0] exp_s,
                             input logic [2:0] exp_v, input bit exp_err,
                             input string err_tag, input int len, input bit next_sync,
                             input logic [12:0] next_tx);
        int n = mode ? 8 : 16;
        comp_sel_i = mode;
        @(posedge clk);
        @(negedge clk);
        sync_i = 1'b0;
        comp_sel_i = ~mode;  // R4: ignored mid-slot
        check(err_tag, 32'(frame_err_o), 32'(exp_err));
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            check("R7 oe active", 32'(tx_oe_o), 1);
            check(mode ? "R3 tx bit" : "R6 tx bit", 32'(tx_bit_o), 32'(exp_tx[15-k]));
            check("R8 no early valid", 32'(rx_valid_o), 0);
            rx_bit_i = rx_slot[15-k];
            @(posedge clk);
        end
        @(negedge clk);
        check("R7 oe released", 32'(tx_oe_o), 0);
        check("R8 valid", 32'(rx_valid_o), 1);
        check(mode ? "R8 code" : "R5 sample", 32'(rx_sample_o), 32'(exp_s));
        check(mode ? "R8 vol" : "R5 vol", 32'(rx_vol_o), 32'(exp_v));
        for (int i = 0; i < len - n - 1; i++) begin
            tx_valid_i = (i == 0);
            tx_data_i  = next_tx;
            @(posedge clk);
            @(negedge clk);
            if (i == 0) check("R8 one-cycle valid", 32'(rx_valid_o), 0);
            if (i == 0) check("R9 err one-cycle", 32'(frame_err_o), 0);
        end
        tx_valid_i = 1'b0;
        if (next_sync) sync_i = 1'b1;
    endtask

    // Linear slot cut short after nbits by a new sync edge (R10).
    task automatic partial_frame(input logic [15:0] exp_tx, input int nbits);
        comp_sel_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        sync_i = 1'b0;
        check("R10 err before abort", 32'(frame_err_o), 0);
        for (int k = 0; k < nbits; k++) begin
            if (k > 0) @(negedge clk);
            check("R11 held tx bit", 32'(tx_bit_o), 32'(exp_tx[15-k]));
            rx_bit_i = ~rx_bit_i;
            @(posedge clk);
        end
        @(negedge clk);
        check("R10 still active", 32'(tx_oe_o), 1);
        check("R10 no valid", 32'(rx_valid_o), 0);
        sync_i = 1'b1;
    endtask

    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        load_tx(13'h1A5C);
        @(negedge clk);
        sync_i = 1'b1;
        // R2 R5 R6: linear frame, first after reset
        run_frame(1'b0, 16'hB6E5, 16'hD2E0, 13'h16DC, 3'd5, 1'b0, "R9 first sync", FL, 1'b1, 13'h00C3);
        // R4 R8: companded
        run_frame(1'b1, 16'h5A00, 16'hC300, 13'h005A, 3'd1, 1'b0, "R9 good len", 29, 1'b1, 13'h00C3);
        // R9 short frame flagged; R11 held word in linear form; negative sample
        run_frame(1'b0, 16'h8001, 16'h0618, 13'h1000, 3'd1, 1'b1, "R9 short", FL, 1'b1, 13'h1FFF);
        // R10 abort after 5 bits
        partial_frame(16'hFFF8, 5);
        run_frame(1'b1, 16'hFF00, 16'hFF00, 13'h00FF, 3'd1, 1'b1, "R10 early sync", 40, 1'b1, 13'h0ABC);
        // R9 long frame flagged
        run_frame(1'b0, 16'h7FFF, 16'h55E0, 13'h0FFF, 3'd7, 1'b1, "R9 long", FL, 1'b1, 13'h0ABC);
        run_frame(1'b1, 16'h3C00, 16'hBC00, 13'h003C, 3'd1, 1'b0, "R10 resync ok", FL, 1'b0, 13'h0ABC);
        repeat (4) @(negedge clk);
        check("R7 idle oe", 32'(tx_oe_o), 0);
        check("R9 idle err", 32'(frame_err_o), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule